// File: doc/BRIEF.md
# Block Move Sequencer

This block runs a memory-to-memory copy for a processor with a 24-bit address space, split into an 8-bit bank and a 16-bit offset. A one-cycle start pulse loads the program counter and bank, the source offset X, the destination offset Y and the count C (bytes to move minus one), together with a direction bit. Each byte then takes one complete pass of seven bus cycles. The pass fetches the instruction byte again, then both bank bytes from the instruction stream, reads one source byte, writes it to the destination, and spends two internal cycles.

The destination bank byte is kept as the data bank register. The count drops by one per byte, and the copy stops after the pass in which C was zero, which leaves C at 0xFFFF. Descending mode decrements both pointers and suits a destination above the source. Ascending mode increments them and suits a destination below the source. A boundary strobe marks the last cycle of every pass, where surrounding logic may take a pending interrupt.

Top module: `blkmv_seq`

## Requirements
- R1: After reset the block is idle: busy=0, rw_n=1, vda=0, iter_end=0, done=0, and x_out, y_out, c_out, dbr_out, pc_out are all zero.
- R2: Every pass drives seven cycles in this order: {bank,PC}, {bank,PC+1}, {bank,PC+2}, {source bank,X}, {destination bank,Y}, then two internal cycles that both show {destination bank,Y}.
- R3: rw_n is 0 only in the fifth cycle of a pass (the write), and wr_data then equals the byte read in the fourth cycle of the same pass.
- R4: vda is 1 exactly in the fourth and fifth cycles of a pass (source read and destination write) and 0 otherwise.
- R5: The byte read in the second cycle of a pass is the destination bank and is loaded into dbr_out. The byte read in the third cycle is the source bank. The byte read in the first cycle has no effect.
- R6: With dir_up=0, X and Y each drop by one after every byte. With dir_up=1, they each rise by one.
- R7: C drops by one after every byte, and C+1 bytes are moved. X, Y and C wrap modulo 65536, so C ends at 0xFFFF.
- R8: Passes before the last one fetch at the unchanged PC. After the last byte, pc_out is PC+3, done pulses during the final cycle of the last pass, and busy falls on the next edge.
- R9: iter_end is 1 in the seventh cycle of every pass and in no other cycle.
- R10: A start pulse while busy=1 is ignored: the running copy and its final register values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| dir_up | input | 1 | 1 = ascending pointers, 0 = descending |
| pc_in | input | 16 | Offset of the move instruction |
| pbr_in | input | 8 | Program bank |
| x_in | input | 16 | Source offset |
| y_in | input | 16 | Destination offset |
| c_in | input | 16 | Byte count minus one |
| rd_data | input | 8 | Bus read data |
| addr | output | 24 | Bus address {bank, offset} |
| wr_data | output | 8 | Bus write data |
| rw_n | output | 1 | 1 = read, 0 = write |
| vda | output | 1 | Valid data address strobe |
| busy | output | 1 | Copy in progress |
| iter_end | output | 1 | Last cycle of a pass |
| done | output | 1 | Last cycle of the final pass |
| x_out | output | 16 | Current source offset |
| y_out | output | 16 | Current destination offset |
| c_out | output | 16 | Current count |
| dbr_out | output | 8 | Data bank register |
| pc_out | output | 16 | Program counter |

## Verification
Start is sampled on a rising edge, and the first cycle of the first pass appears in the very next cycle. After that, one bus cycle follows per clock with no gaps, so the expected trace is fixed cycle for cycle. The driver builds the full 7×(C+1) cycle trace before it raises start. The monitor then pops one item at every falling edge while busy is high and compares addr, rw_n, vda, iter_end, done and, on write cycles, wr_data. The final register values are checked once busy has fallen, one edge after the done cycle.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
   typedef enum logic [2:0] {
      PH_OP  = 3'd0,
      PH_DBK = 3'd1,
      PH_SBK = 3'd2,
      PH_RD  = 3'd3,
      PH_WR  = 3'd4,
      PH_IO1 = 3'd5,
      PH_IO2 = 3'd6
   } phase_t;
endpackage

// File: rtl/blkmv_phase.sv
module blkmv_phase
   import blkmv_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   last,
   output logic   busy,
   output phase_t phase,
   output logic   iter_end,
   output logic   finish
);
   assign iter_end = busy && (phase == PH_IO2);
   assign finish   = iter_end && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= PH_OP;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            phase <= PH_OP;
         end
      end else if (phase == PH_IO2) begin
         phase <= PH_OP;
         if (last) busy <= 1'b0;
      end else begin
         phase <= phase_t'(phase + 3'd1);
      end
   end
endmodule

// File: rtl/blkmv_step.sv
module blkmv_step #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         up,
   input  logic [W-1:0] init,
   output logic [W-1:0] val
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= '0;
      else if (load) val <= init;
      else if (step) val <= up ? val + ONE : val - ONE;
   end
endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
   import blkmv_pkg::*;
#(
   parameter int OFF_W  = 16,
   parameter int BANK_W = 8,
   parameter int DATA_W = 8,
   parameter int INSN_LEN = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    dir_up,
   input  logic [OFF_W-1:0]        pc_in,
   input  logic [BANK_W-1:0]       pbr_in,
   input  logic [OFF_W-1:0]        x_in,
   input  logic [OFF_W-1:0]        y_in,
   input  logic [OFF_W-1:0]        c_in,
   input  logic [DATA_W-1:0]       rd_data,
   output logic [BANK_W+OFF_W-1:0] addr,
   output logic [DATA_W-1:0]       wr_data,
   output logic                    rw_n,
   output logic                    vda,
   output logic                    busy,
   output logic                    iter_end,
   output logic                    done,
   output logic [OFF_W-1:0]        x_out,
   output logic [OFF_W-1:0]        y_out,
   output logic [OFF_W-1:0]        c_out,
   output logic [BANK_W-1:0]       dbr_out,
   output logic [OFF_W-1:0]        pc_out
);
   localparam int NPTR = 2;
   localparam logic [OFF_W-1:0] ONE  = OFF_W'(1);
   localparam logic [OFF_W-1:0] SKIP = OFF_W'(INSN_LEN);

   if (OFF_W < 8 || BANK_W < 1 || DATA_W < BANK_W) begin : g_bad_width
      $error("blkmv_seq: unsupported width parameters");
   end
   if (INSN_LEN < 3) begin : g_bad_len
      $error("blkmv_seq: instruction must span opcode and two bank bytes");
   end

   phase_t            phase;
   logic              load;
   logic              dir_q;
   logic [BANK_W-1:0] pbr_q;
   logic [BANK_W-1:0] sbk_q;
   logic [DATA_W-1:0] hold_q;
   logic [OFF_W-1:0]  ptr_init [NPTR];
   logic [OFF_W-1:0]  ptr_val  [NPTR];

   assign load = start && !busy;

   blkmv_phase u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .last     (c_out == '0),
      .busy     (busy),
      .phase    (phase),
      .iter_end (iter_end),
      .finish   (done)
   );

   assign ptr_init[0] = x_in;
   assign ptr_init[1] = y_in;

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      blkmv_step #(.W(OFF_W)) u_step (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .step  (iter_end),
         .up    (dir_q),
         .init  (ptr_init[i]),
         .val   (ptr_val[i])
      );
   end

   assign x_out = ptr_val[0];
   assign y_out = ptr_val[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_out   <= '0;
         pc_out  <= '0;
         pbr_q   <= '0;
         dir_q   <= 1'b0;
         dbr_out <= '0;
         sbk_q   <= '0;
         hold_q  <= '0;
      end else if (load) begin
         c_out  <= c_in;
         pc_out <= pc_in;
         pbr_q  <= pbr_in;
         dir_q  <= dir_up;
      end else if (busy) begin
         case (phase)
            PH_DBK:  dbr_out <= rd_data[BANK_W-1:0];
            PH_SBK:  sbk_q   <= rd_data[BANK_W-1:0];
            PH_RD:   hold_q  <= rd_data;
            PH_IO2: begin
               c_out <= c_out - ONE;
               if (done) pc_out <= pc_out + SKIP;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      addr = {pbr_q, pc_out};
      if (busy) begin
         case (phase)
            PH_OP:   addr = {pbr_q, pc_out};
            PH_DBK:  addr = {pbr_q, pc_out + ONE};
            PH_SBK:  addr = {pbr_q, pc_out + ONE + ONE};
            PH_RD:   addr = {sbk_q, x_out};
            default: addr = {dbr_out, y_out};
         endcase
      end
   end

   assign wr_data = hold_q;
   assign rw_n    = !(busy && phase == PH_WR);
   assign vda     = busy && (phase == PH_RD || phase == PH_WR);
endmodule

// File: rtl/blkmv_seq_chk.sv
module blkmv_seq_chk #(
   parameter int OFF_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             rw_n,
   input logic             vda,
   input logic             iter_end,
   input logic             done,
   input logic [OFF_W-1:0] x_out,
   input logic [OFF_W-1:0] y_out,
   input logic [OFF_W-1:0] c_out,
   input logic [OFF_W-1:0] pc_out
);
   AST_WRITE_HAS_VDA: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_n |-> vda); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rw_n && !vda && !iter_end)); // R4
   AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_n |=> rw_n); // R3
   AST_BOUNDARY_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      iter_end |=> !iter_end); // R9
   AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      iter_end |=> c_out == $past(c_out) - 1'b1); // R7
   AST_X_MOVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      iter_end |=> (x_out == $past(x_out) + 1'b1 || x_out == $past(x_out) - 1'b1)); // R6
   AST_XY_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      iter_end |=> (x_out - $past(x_out)) == (y_out - $past(y_out))); // R6
   AST_FINISH_PC: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && pc_out == $past(pc_out) + 16'd3)); // R8
   AST_DONE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (iter_end && c_out == '0)); // R8
endmodule

bind blkmv_seq blkmv_seq_chk #(.OFF_W(OFF_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rw_n     (rw_n),
   .vda      (vda),
   .iter_end (iter_end),
   .done     (done),
   .x_out    (x_out),
   .y_out    (y_out),
   .c_out    (c_out),
   .pc_out   (pc_out)
);

// File: tb/blkmv_seq_bench.sv
module blkmv_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir_up = 1'b0;
   logic [15:0] pc_in = '0, x_in = '0, y_in = '0, c_in = '0;
   logic [7:0]  pbr_in = '0;
   logic [7:0]  rd_data;
   logic [23:0] addr;
   logic [7:0]  wr_data, dbr_out;
   logic        rw_n, vda, busy, iter_end, done;
   logic [15:0] x_out, y_out, c_out, pc_out;

   int errors = 0;
   int checks = 0;

   logic [15:0] t_pc;
   logic [7:0]  t_pbr, t_dbk, t_sbk;

   typedef struct {
      logic [23:0] a;
      logic        rw;
      logic        vd;
      logic        it;
      logic        dn;
      logic [7:0]  wd;
   } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk;

   blkmv_seq u_blkmv_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_up(dir_up),
      .pc_in(pc_in), .pbr_in(pbr_in), .x_in(x_in), .y_in(y_in), .c_in(c_in),
      .rd_data(rd_data), .addr(addr), .wr_data(wr_data), .rw_n(rw_n),
      .vda(vda), .busy(busy), .iter_end(iter_end), .done(done),
      .x_out(x_out), .y_out(y_out), .c_out(c_out), .dbr_out(dbr_out),
      .pc_out(pc_out)
   );

   function automatic logic [7:0] hash(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ (a[23:16] + 8'h3C);
   endfunction

   always_comb begin
      if (addr == {t_pbr, t_pc + 16'd1})      rd_data = t_dbk;
      else if (addr == {t_pbr, t_pc + 16'd2}) rd_data = t_sbk;
      else                                    rd_data = hash(addr);
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [23:0] a, input logic rw, input logic vd,
                       input logic it, input logic dn, input logic [7:0] wd);
      item_t e;
      e.a = a; e.rw = rw; e.vd = vd; e.it = it; e.dn = dn; e.wd = wd;
      exp_q.push_back(e);
   endtask

   // monitor: one expected item per busy cycle
   always @(negedge clk) begin
      if (rst_n && busy) begin
         if (exp_q.size() == 0) begin
            check("R2", "unexpected extra busy cycle", 32'd1, 32'd0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            check("R2", "addr", 32'(addr), 32'(e.a));
            check("R3", "rw_n", 32'(rw_n), 32'(e.rw));
            check("R4", "vda", 32'(vda), 32'(e.vd));
            check("R9", "iter_end", 32'(iter_end), 32'(e.it));
            check("R8", "done", 32'(done), 32'(e.dn));
            if (!e.rw) check("R3", "wr_data", 32'(wr_data), 32'(e.wd));
         end
      end
   end

   // driver: build full expected trace, start, optionally poke start again
   task automatic run(input logic up, input logic [15:0] pc, input logic [7:0] pbr,
                      input logic [7:0] dbk, input logic [7:0] sbk,
                      input logic [15:0] x, input logic [15:0] y,
                      input logic [15:0] c, input bit poke);
      logic [15:0] xs = x, ys = y;
      t_pc = pc; t_pbr = pbr; t_dbk = dbk; t_sbk = sbk;
      for (int i = 0; i <= int'(c); i++) begin
         push({pbr, pc}, 1, 0, 0, 0, 8'h00);
         push({pbr, pc + 16'd1}, 1, 0, 0, 0, 8'h00);
         push({pbr, pc + 16'd2}, 1, 0, 0, 0, 8'h00);
         push({sbk, xs}, 1, 1, 0, 0, 8'h00);
         push({dbk, ys}, 0, 1, 0, 0, hash({sbk, xs}));
         push({dbk, ys}, 1, 0, 0, 0, 8'h00);
         push({dbk, ys}, 1, 0, 1, (i == int'(c)), 8'h00);
         xs = up ? xs + 16'd1 : xs - 16'd1;
         ys = up ? ys + 16'd1 : ys - 16'd1;
      end
      @(negedge clk);
      dir_up = up; pc_in = pc; pbr_in = pbr; x_in = x; y_in = y; c_in = c;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         dir_up = ~up; x_in = 16'h1234; y_in = 16'h4321; c_in = 16'h0009;
         pc_in = 16'h0AAA; start = 1'b1; // R10: must be ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      check("R6", "x_out final", 32'(x_out), 32'(xs));
      check("R6", "y_out final", 32'(y_out), 32'(ys));
      check("R7", "c_out final", 32'(c_out), 32'hFFFF);
      check("R5", "dbr_out", 32'(dbr_out), 32'(dbk));
      check("R8", "pc_out", 32'(pc_out), 32'(pc + 16'd3));
      check("R2", "trace fully consumed", 32'(exp_q.size()), 32'd0);
      if (poke) check("R10", "busy after ignored start", 32'(busy), 32'd0);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_pc = '0; t_pbr = '0; t_dbk = '0; t_sbk = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", 32'(busy), 32'd0);
      check("R1", "rw_n", 32'(rw_n), 32'd1);
      check("R1", "vda", 32'(vda), 32'd0);
      check("R1", "iter_end/done", 32'({iter_end, done}), 32'd0);
      check("R1", "x/y", 32'({x_out, y_out}), 32'd0);
      check("R1", "c/pc", 32'({c_out, pc_out}), 32'd0);
      check("R1", "dbr", 32'(dbr_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 descending, R7 X wraps below zero, three bytes
      run(1'b0, 16'h8000, 8'h01, 8'h22, 8'h11, 16'h0001, 16'h2010, 16'd2, 1'b0);
      // R7 single byte when C=0, ascending
      run(1'b1, 16'h4100, 8'h02, 8'h33, 8'h44, 16'h0500, 16'h0100, 16'd0, 1'b0);
      // R10 start while busy ignored, ascending, Y wraps above 0xFFFF
      run(1'b1, 16'hC000, 8'h05, 8'h66, 8'h77, 16'h0200, 16'hFFFE, 16'd3, 1'b1);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule